// File: doc/BRIEF.md
# Floating-Point Status Word Update Unit

This block owns the 32-bit status and control word that sits next to a floating-point arithmetic unit. It decodes two control fields from the word: the rounding mode and a flag that flushes denormals to zero. The arithmetic unit reports its five raw exception flags through a strobe. The block merges those flags into a sticky field in the upper bits of the word. In the same cycle it checks them against the five trap-enable bits. When an enabled exception is present, it pulses a trap request.

Compare results arrive through a second strobe, as a relation code together with a condition mask. The relation picks one mask bit as the result. A nonzero target index writes that result straight into one bit of a group of directly addressed compare bits. A target index of zero pushes the result into the primary condition bit. The old condition bit then moves into the head of a ten-deep history queue, which shifts down by one place. Software can load the whole word through a write port. The arithmetic itself is outside this block.

Top module: `fpsw_unit`

## Requirements
- R1: While reset is asserted, and right after it, the status word is zero, the rounding mode output is 0, flushEn is 0 and trapPulse is 0.
- R2: A write strobe loads wrData into the status word, and the new value is visible on the output after the next clock edge.
- R3: roundMode always shows word bits 10:9, with this encoding: 0 is nearest-even, 1 is toward zero, 2 is toward plus infinity and 3 is toward minus infinity.
- R4: flushEn always shows word bit 5.
- R5: A flag report ORs the 5-bit raw flag value into word bits 31:27. The flags are encoded as inexact bit 0, underflow bit 1, overflow bit 2, divide-by-zero bit 3 and invalid bit 4. Earlier sticky flags are kept.
- R6: trapPulse goes high for exactly one cycle, in the cycle after a flag report whose raw flags ANDed with word bits 4:0 give a nonzero value. Otherwise it stays low.
- R7: A flag report with all raw flags zero leaves the word unchanged and raises no trap.
- R8: The compare result is one bit of cmpMask, selected by cmpRel: code 0 (greater) selects mask bit 4, 1 (less) selects bit 3, 2 (equal) selects bit 2 and 3 (unordered) selects bit 1. Mask bit 0 (the signaling-compare select) has no effect on the word.
- R9: A compare with target index y from 1 to 7 writes the result into word bit 22 minus y. No other bit changes.
- R10: A compare with target index 0 moves bits 21:12 into bits 20:11 and old bit 26 into bit 21. It then puts the result into bit 26. All other bits are kept.
- R11: When a flag report and a compare arrive in the same cycle, the flags are merged first and the compare update is applied to the merged word.
- R12: A write in the same cycle as a flag report or a compare takes precedence. The word becomes wrData and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load strobe for the status word |
| wrData | input | 32 | Value to load |
| flagValid | input | 1 | Raw exception flag report strobe |
| flagRaw | input | 5 | Raw exception flags |
| cmpValid | input | 1 | Compare result strobe |
| cmpRel | input | 2 | Relation code (0 gt, 1 lt, 2 eq, 3 unordered) |
| cmpMask | input | 5 | Condition mask |
| cmpTarget | input | 3 | Compare target index, 0 selects the queue |
| statusWord | output | 32 | Current status word |
| roundMode | output | 2 | Decoded rounding mode |
| flushEn | output | 1 | Denormal flush enable |
| trapPulse | output | 1 | One-cycle trap request |

## Verification
Flag reports are applied with flags whose enables are set and with flags whose enables are clear, with an all-zero report, and on top of flags that are already sticky. Together these separate the OR merge from the trap condition. Compare strobes are driven with each relation code and with targets 1 and 7. The targets cover both ends of the targeted group, with a background of all ones that shows a cleared bit and a background of zeros that shows a set bit. The queue case uses asymmetric patterns, so a shift in the wrong direction or a lost bit 26 changes the result. Cycles with several strobes at once separate the ordering of flags before compare and the precedence of the write port.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
  localparam int WORD_W    = 32;
  localparam int FLAG_W    = 5;
  localparam int FLAG_LSB  = 27;
  localparam int RM_LSB    = 9;
  localparam int RM_W      = 2;
  localparam int FLUSH_POS = 5;
  localparam int QHEAD     = 21;
  localparam int QLEN      = 10;
  localparam int CBIT      = 26;
  localparam int TGT_W     = 3;
  localparam int MASK_W    = 5;
  localparam int POS_W     = $clog2(WORD_W);

  typedef enum logic [RM_W-1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_POS  = 2'd2,
    RND_NEG  = 2'd3
  } rnd_e;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic             load;
    logic             merge;
    logic             cmpTgt;
    logic             cmpQueue;
    logic             cmpBit;
    logic [POS_W-1:0] tgtPos;
  } upd_t;
endpackage

// File: rtl/fpsw_ctrl.sv
module fpsw_ctrl
  import fpsw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              flagValid,
  input  logic [FLAG_W-1:0] flagRaw,
  input  logic              cmpValid,
  input  logic [1:0]        cmpRel,
  input  logic [MASK_W-1:0] cmpMask,
  input  logic [TGT_W-1:0]  cmpTarget,
  input  logic [FLAG_W-1:0] trapEnables,
  output upd_t              upd,
  output logic              trapPulse
);
  logic selBit;
  logic trapNext;

  // Relation code picks one condition-mask bit; mask bit 0 is never used here.
  always_comb begin
    unique case (rel_e'(cmpRel))
      REL_GT:  selBit = cmpMask[4];
      REL_LT:  selBit = cmpMask[3];
      REL_EQ:  selBit = cmpMask[2];
      default: selBit = cmpMask[1];
    endcase
  end

  always_comb begin
    upd.load     = wrEn;
    upd.merge    = flagValid && !wrEn;
    upd.cmpTgt   = cmpValid && !wrEn && (cmpTarget != '0);
    upd.cmpQueue = cmpValid && !wrEn && (cmpTarget == '0);
    upd.cmpBit   = selBit;
    upd.tgtPos   = POS_W'(QHEAD + 1) - POS_W'(cmpTarget);
  end

  // Merging flags never touches the enable field, so the pre-merge enables
  // equal the enables of the updated word.
  assign trapNext = upd.merge && ((flagRaw & trapEnables) != '0);

  always_ff @(posedge clk) begin
    if (!rstN) trapPulse <= 1'b0;
    else       trapPulse <= trapNext;
  end

  // R6
  trap_on_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagValid && !wrEn && ((flagRaw & trapEnables) != '0)) |=> trapPulse);

  // R6
  trap_needs_report_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past(flagValid) && !$past(wrEn));

  // R12
  trap_blocked_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !trapPulse);
endmodule

// File: rtl/fpsw_dpath.sv
module fpsw_dpath
  import fpsw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  upd_t              upd,
  input  logic [WORD_W-1:0] wrData,
  input  logic [FLAG_W-1:0] flagRaw,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] nextWord;

  always_comb begin
    merged = word;
    if (upd.merge && (flagRaw != '0))
      merged[FLAG_LSB +: FLAG_W] = word[FLAG_LSB +: FLAG_W] | flagRaw;
  end

  always_comb begin
    nextWord = merged;
    if (upd.cmpTgt) begin
      nextWord[upd.tgtPos] = upd.cmpBit;
    end else if (upd.cmpQueue) begin
      for (int i = 0; i < QLEN; i++)
        nextWord[QHEAD-QLEN+i] = merged[QHEAD-QLEN+1+i];
      nextWord[QHEAD] = merged[CBIT];
      nextWord[CBIT]  = upd.cmpBit;
    end
    if (upd.load) nextWord = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) word <= '0;
    else       word <= nextWord;
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    upd.load |=> word == $past(wrData));

  // R7
  zero_flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upd.merge && flagRaw == '0 && !upd.cmpTgt && !upd.cmpQueue && !upd.load)
      |=> $stable(word));

  // R9
  target_bit_written_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upd.cmpTgt && !upd.load) |=> word[$past(upd.tgtPos)] == $past(upd.cmpBit));

  // R10
  queue_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upd.cmpQueue && !upd.load) |=> word[CBIT] == $past(upd.cmpBit)
                                   && word[QHEAD] == $past(word[CBIT]));
endmodule

// File: rtl/fpsw_unit.sv
module fpsw_unit
  import fpsw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              flagValid,
  input  logic [FLAG_W-1:0] flagRaw,
  input  logic              cmpValid,
  input  logic [1:0]        cmpRel,
  input  logic [MASK_W-1:0] cmpMask,
  input  logic [TGT_W-1:0]  cmpTarget,
  output logic [WORD_W-1:0] statusWord,
  output logic [RM_W-1:0]   roundMode,
  output logic              flushEn,
  output logic              trapPulse
);
  upd_t              upd;
  logic [WORD_W-1:0] word;
  rnd_e              rnd;

  fpsw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .flagValid(flagValid), .flagRaw(flagRaw),
    .cmpValid(cmpValid), .cmpRel(cmpRel), .cmpMask(cmpMask),
    .cmpTarget(cmpTarget), .trapEnables(word[FLAG_W-1:0]),
    .upd(upd), .trapPulse(trapPulse)
  );

  fpsw_dpath u_dpath (
    .clk(clk), .rstN(rstN), .upd(upd), .wrData(wrData),
    .flagRaw(flagRaw), .word(word)
  );

  assign rnd        = rnd_e'(word[RM_LSB +: RM_W]);
  assign roundMode  = rnd;
  assign flushEn    = word[FLUSH_POS];
  assign statusWord = word;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> statusWord == '0 && !trapPulse);
endmodule

// File: tb/fpsw_unit_test.sv
module fpsw_unit_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [31:0] wrData;
  logic        flagValid;
  logic [4:0]  flagRaw;
  logic        cmpValid;
  logic [1:0]  cmpRel;
  logic [4:0]  cmpMask;
  logic [2:0]  cmpTarget;
  logic [31:0] statusWord;
  logic [1:0]  roundMode;
  logic        flushEn;
  logic        trapPulse;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fpsw_unit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .flagValid(flagValid), .flagRaw(flagRaw),
    .cmpValid(cmpValid), .cmpRel(cmpRel), .cmpMask(cmpMask), .cmpTarget(cmpTarget),
    .statusWord(statusWord), .roundMode(roundMode), .flushEn(flushEn),
    .trapPulse(trapPulse)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [31:0] pre;
    logic        fv;
    logic [4:0]  flags;
    logic        cv;
    logic [1:0]  rel;
    logic [4:0]  mask;
    logic [2:0]  tgt;
    logic [31:0] expWord;
    logic        expTrap;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    // R5 flags merged, enables clear
    '{8'd5,  32'h0000_0000, 1'b1, 5'b00101, 1'b0, 2'd0, 5'b00000, 3'd0, 32'h2800_0000, 1'b0},
    // R6 overflow enabled and reported
    '{8'd6,  32'h0000_0004, 1'b1, 5'b00100, 1'b0, 2'd0, 5'b00000, 3'd0, 32'h2000_0004, 1'b1},
    // R6 enable does not match reported flag
    '{8'd6,  32'h0000_0001, 1'b1, 5'b10000, 1'b0, 2'd0, 5'b00000, 3'd0, 32'h8000_0001, 1'b0},
    // R7 all-zero report
    '{8'd7,  32'h1234_5678, 1'b1, 5'b00000, 1'b0, 2'd0, 5'b00000, 3'd0, 32'h1234_5678, 1'b0},
    // R5 sticky flags are kept
    '{8'd5,  32'h0800_0000, 1'b1, 5'b00010, 1'b0, 2'd0, 5'b00000, 3'd0, 32'h1800_0000, 1'b0},
    // R9 target 1, greater
    '{8'd9,  32'h0000_0000, 1'b0, 5'b00000, 1'b1, 2'd0, 5'b10000, 3'd1, 32'h0020_0000, 1'b0},
    // R9 target 7, less
    '{8'd9,  32'h0000_0000, 1'b0, 5'b00000, 1'b1, 2'd1, 5'b01000, 3'd7, 32'h0000_8000, 1'b0},
    // R8 equal selects a clear bit, target 3 cleared
    '{8'd8,  32'hFFFF_FFFF, 1'b0, 5'b00000, 1'b1, 2'd2, 5'b11011, 3'd3, 32'hFFF7_FFFF, 1'b0},
    // R10 queue shift with result 1
    '{8'd10, 32'h0420_1000, 1'b0, 5'b00000, 1'b1, 2'd3, 5'b00010, 3'd0, 32'h0430_0800, 1'b0},
    // R10 queue shift with result 0, outside bits kept
    '{8'd10, 32'h8000_1801, 1'b0, 5'b00000, 1'b1, 2'd0, 5'b01111, 3'd0, 32'h8000_0801, 1'b0},
    // R8 signaling bit alone gives a zero result
    '{8'd8,  32'h0020_0000, 1'b0, 5'b00000, 1'b1, 2'd0, 5'b00001, 3'd1, 32'h0000_0000, 1'b0},
    // R11 flags and queued compare together
    '{8'd11, 32'h0400_0010, 1'b1, 5'b10000, 1'b1, 2'd2, 5'b00100, 3'd0, 32'h8420_0010, 1'b1},
    // R11 flags and targeted compare together
    '{8'd11, 32'h0000_0000, 1'b1, 5'b00001, 1'b1, 2'd1, 5'b01000, 3'd2, 32'h0810_0000, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; wrData = '0; flagValid = 0; flagRaw = '0;
    cmpValid = 0; cmpRel = '0; cmpMask = '0; cmpTarget = '0;
  endtask

  task automatic load(input logic [31:0] val);
    @(negedge clk);
    idle();
    wrEn = 1; wrData = val;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 word", statusWord, 32'h0);
    check("R1 round", {30'b0, roundMode}, 32'h0);
    check("R1 flush", {31'b0, flushEn}, 32'h0);
    check("R1 trap", {31'b0, trapPulse}, 32'h0);
    rstN = 1;

    // R2 load
    load(32'hA5C3_0F96);
    check("R2 load", statusWord, 32'hA5C3_0F96);

    // R3 rounding decode, R4 flush decode
    for (int m = 0; m < 4; m++) begin
      load(32'(m) << 9);
      check("R3 round", {30'b0, roundMode}, 32'(m));
      check("R4 flush off", {31'b0, flushEn}, 32'h0);
    end
    load(32'h0000_0020);
    check("R4 flush on", {31'b0, flushEn}, 32'h1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      load(VECS[i].pre);
      flagValid = VECS[i].fv; flagRaw = VECS[i].flags;
      cmpValid = VECS[i].cv; cmpRel = VECS[i].rel;
      cmpMask = VECS[i].mask; cmpTarget = VECS[i].tgt;
      @(negedge clk);
      idle();
      check($sformatf("R%0d vec%0d word", VECS[i].req, i), statusWord, VECS[i].expWord);
      check($sformatf("R%0d vec%0d trap", VECS[i].req, i), {31'b0, trapPulse},
            {31'b0, VECS[i].expTrap});
    end

    // R6 pulse lasts one cycle
    load(32'h0000_001F);
    flagValid = 1; flagRaw = 5'b01000;
    @(negedge clk);
    idle();
    check("R6 pulse high", {31'b0, trapPulse}, 32'h1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'b0, trapPulse}, 32'h0);
    check("R6 word", statusWord, 32'h4000_001F);

    // R12 write wins over flag report and compare
    load(32'h0000_001F);
    wrEn = 1; wrData = 32'h0000_0600;
    flagValid = 1; flagRaw = 5'b11111;
    cmpValid = 1; cmpRel = 2'd0; cmpMask = 5'b10000; cmpTarget = 3'd0;
    @(negedge clk);
    idle();
    check("R12 word", statusWord, 32'h0000_0600);
    check("R12 trap", {31'b0, trapPulse}, 32'h0);
    check("R3 after R12", {30'b0, roundMode}, 32'h3);

    // R1 reset mid-run
    load(32'hFFFF_FFFF);
    rstN = 0;
    @(negedge clk);
    check("R1 mid reset", statusWord, 32'h0);
    rstN = 1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule